// File: doc/BRIEF.md
# Edge-Change Timestamp Logger

This block watches a bank of digital inputs and writes down when any of them changes. The inputs are synchronised, then sampled together on every tick of a programmable timebase. A free-running tick counter supplies the time. The block compares each sample with the one before it. Only when at least one enabled channel has changed does it store a record: which channels changed, the new level of every channel, and the tick count. Records wait in a small event queue until software reads them. Software derives frequency and duty cycle from consecutive records for each channel.

The block also provides:
- an optional glitch filter on each channel, which ignores pulses shorter than a programmable number of ticks;
- a sticky flag for each channel that marks a pulse which came and went between two ticks;
- a sticky overflow bit for records lost because the queue was full.

Top module: `edge_event_logger`

## Requirements
- R1: All channels are sampled on the same tick. Every enabled channel that changed on that tick appears in one record, and that record carries a single timestamp.
- R2: A rising level and a falling level on an enabled channel each produce a record.
- R3: A record is stored only when at least one enabled channel's accepted level differs from the level accepted on the previous tick. The record holds:
  - a mask with bit i set when channel i changed;
  - the accepted levels of all channels after the tick;
  - the tick count at that tick, where the first tick after reset has count 0.
- R4: A tick occurs once every `presc_div`+1 clock cycles. The timestamp counts ticks, so two input changes N*(`presc_div`+1) clocks apart are logged with timestamps N apart.
- R5: Each input passes through a two-stage synchroniser. A change on `din` can be accepted at the earliest on a tick two or more clocks after the change.
- R6: A channel's narrow-pulse flag is set on a tick when two conditions hold: its synchronised input moved at some point since the previous tick, and its level at this tick equals its level at the previous tick. The flag stays set until `narrow_clr`; if both happen in the same cycle, setting wins.
- R7: With `filt_en` high and `filt_len`=N, a new level is accepted only after it has been seen on N+1 consecutive ticks. Shorter pulses produce no record.
- R8: A channel whose `ch_enable` bit is low never contributes to a record mask and never sets its narrow-pulse flag.
- R9: The queue holds 16 records. A record that arrives while the queue is full is dropped, even if a read happens in the same cycle, and `overflow` is set. `overflow` stays set until `ovf_clr`; if both happen in the same cycle, setting wins.
- R10: The read port shows the oldest record while `rd_valid` is high, and `rd_en` removes that record. `rd_en` while the queue is empty has no effect.
- R11: After reset the queue is empty, and `overflow` and all narrow-pulse flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NCH | Raw channel inputs |
| ch_enable | input | NCH | Per-channel enable for records and narrow-pulse flags |
| presc_div | input | PW | Tick period minus one, in clocks |
| filt_en | input | 1 | Enables the glitch filter |
| filt_len | input | FW | Filter length N; a level must persist N+1 ticks |
| rd_en | input | 1 | Removes the head record |
| ovf_clr | input | 1 | Clears `overflow` |
| narrow_clr | input | 1 | Clears all narrow-pulse flags |
| rd_valid | output | 1 | Queue not empty |
| rd_ts | output | 32 | Head record timestamp |
| rd_mask | output | NCH | Head record changed-channel mask |
| rd_levels | output | NCH | Head record levels |
| overflow | output | 1 | Sticky record-lost flag |
| narrow_flag | output | NCH | Sticky narrow-pulse flags |

## Verification
The embedded assertions check, on every cycle, the invariants that do not depend on stimulus timing:
- the queue never exceeds its depth;
- a read on an empty queue leaves it empty;
- the timestamp moves only on a tick;
- every stored record has a non-empty mask;
- the overflow and narrow-pulse flags are sticky;
- a disabled channel never raises its narrow-pulse flag.

The remaining behaviours can only be shown by the bench's scenarios, which compare against a cycle-level reference model:
- the exact content of each record;
- the tick spacing between records;
- the synchroniser delay;
- glitch rejection by the filter;
- detection of pulses shorter than a tick;
- dropping records when the queue is full.

// File: rtl/elog_pkg.sv
package elog_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t ts;
    word_t mask;
    word_t lev;
  } evt_rec_t;
  localparam int REC_W = $bits(evt_rec_t);
endpackage

// File: rtl/elog_tick.sv
module elog_tick #(
  parameter int PW = 16,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] div,
  output logic          tick,
  output logic [TW-1:0] ts
);
  logic [PW-1:0] pc_q, pc_d;
  logic [TW-1:0] ts_q, ts_d;

  assign tick = (pc_q >= div);
  assign ts   = ts_q;

  always_comb begin
    pc_d = tick ? '0 : pc_q + 1'b1;
    ts_d = tick ? ts_q + 1'b1 : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ts_q <= '0;
    end else begin
      pc_q <= pc_d;
      ts_q <= ts_d;
    end
  end

  // R4
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts_q));
endmodule

// File: rtl/elog_chan.sv
module elog_chan #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          tick,
  input  logic          en,
  input  logic          filt_en,
  input  logic [FW-1:0] filt_len,
  input  logic          narrow_clr,
  output logic          lev_cur,
  output logic          lev_nxt,
  output logic          narrow
);
  logic s1_q, s2_q, s2d_q, raw_q, raw_d, act_q, act_d;
  logic lev_q, lev_d, nar_q, nar_d, seen, nar_set;
  logic [FW-1:0] fc_q, fc_d;

  assign seen    = act_q | (s2_q ^ s2d_q);
  assign nar_set = tick & en & seen & (s2_q == raw_q);

  always_comb begin
    fc_d    = '0;
    lev_nxt = lev_q;
    if (!filt_en) begin
      lev_nxt = s2_q;
    end else if (s2_q != lev_q) begin
      if (fc_q >= filt_len) lev_nxt = s2_q;
      else                  fc_d    = fc_q + 1'b1;
    end
    act_d = tick ? 1'b0 : seen;
    raw_d = tick ? s2_q : raw_q;
    lev_d = tick ? lev_nxt : lev_q;
    nar_d = nar_set | (nar_q & ~narrow_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s2d_q <= 1'b0;
      raw_q <= 1'b0;
      act_q <= 1'b0;
      lev_q <= 1'b0;
      fc_q  <= '0;
      nar_q <= 1'b0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      s2d_q <= s2_q;
      raw_q <= raw_d;
      act_q <= act_d;
      lev_q <= lev_d;
      nar_q <= nar_d;
      if (tick) fc_q <= fc_d;
    end
  end

  assign lev_cur = lev_q;
  assign narrow  = nar_q;

  // R6
  narrow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nar_q && !narrow_clr) |=> nar_q);
  // R8
  narrow_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !nar_q) |=> !nar_q);
endmodule

// File: rtl/elog_fifo.sv
module elog_fifo #(
  parameter int DW    = 96,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q, cnt_d;
  logic          push, pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign push  = wr & ~full;
  assign pop   = rd & ~empty;
  assign rdata = mem[rp_q];

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  // R9
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd) |=> full);
  // R10
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr) |=> empty);
endmodule

// File: rtl/edge_event_logger.sv
module edge_event_logger
  import elog_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int PW    = 16,
  parameter int FW    = 4,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] ch_enable,
  input  logic [PW-1:0]  presc_div,
  input  logic           filt_en,
  input  logic [FW-1:0]  filt_len,
  input  logic           rd_en,
  input  logic           ovf_clr,
  input  logic           narrow_clr,
  output logic           rd_valid,
  output logic [31:0]    rd_ts,
  output logic [NCH-1:0] rd_mask,
  output logic [NCH-1:0] rd_levels,
  output logic           overflow,
  output logic [NCH-1:0] narrow_flag
);
  logic           tick, fifo_empty, fifo_full, rec_req, ovf_q, ovf_d;
  word_t          ts;
  logic [NCH-1:0] lev_cur, lev_nxt, chg_mask;
  evt_rec_t       rec_in, rec_out;

  elog_tick #(.PW(PW), .TW(WORD_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(presc_div), .tick(tick), .ts(ts)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    elog_chan #(.FW(FW)) u_ch (
      .clk(clk), .rst_n(rst_n), .din(din[i]), .tick(tick),
      .en(ch_enable[i]), .filt_en(filt_en), .filt_len(filt_len),
      .narrow_clr(narrow_clr), .lev_cur(lev_cur[i]),
      .lev_nxt(lev_nxt[i]), .narrow(narrow_flag[i])
    );
  end

  always_comb begin
    chg_mask = (lev_nxt ^ lev_cur) & ch_enable;
    rec_req  = tick & (|chg_mask);
    rec_in   = '0;
    rec_in.ts            = ts;
    rec_in.mask[NCH-1:0] = chg_mask;
    rec_in.lev[NCH-1:0]  = lev_nxt;
    ovf_d    = (rec_req & fifo_full) | (ovf_q & ~ovf_clr);
  end

  elog_fifo #(.DW(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(rec_req), .wdata(rec_in),
    .rd(rd_en), .rdata(rec_out), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign rd_valid  = ~fifo_empty;
  assign rd_ts     = rec_out.ts;
  assign rd_mask   = rec_out.mask[NCH-1:0];
  assign rd_levels = rec_out.lev[NCH-1:0];
  assign overflow  = ovf_q;

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R3
  record_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_req |-> (rec_in.mask != '0));
endmodule

// File: tb/tb_edge_event_logger.sv
module tb_edge_event_logger;
  localparam int NCH = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] din = '0, ch_enable = '1;
  logic [15:0] presc_div = '0;
  logic filt_en = 1'b0;
  logic [3:0] filt_len = '0;
  logic rd_en = 1'b0, ovf_clr = 1'b0, narrow_clr = 1'b0;
  logic rd_valid, overflow;
  logic [31:0] rd_ts;
  logic [NCH-1:0] rd_mask, rd_levels, narrow_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_event_logger #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ch_enable(ch_enable),
    .presc_div(presc_div), .filt_en(filt_en), .filt_len(filt_len),
    .rd_en(rd_en), .ovf_clr(ovf_clr), .narrow_clr(narrow_clr),
    .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_mask(rd_mask),
    .rd_levels(rd_levels), .overflow(overflow), .narrow_flag(narrow_flag)
  );

  // Behavioural reference model
  bit [NCH-1:0] m_s1, m_s2, m_s2d, m_raw, m_act, m_lev, m_nar;
  int m_fc [NCH];
  int m_pc, m_ts;
  bit m_ovf;
  int unsigned q_ts[$];
  bit [NCH-1:0] q_mask[$], q_lev[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s2d = '0; m_raw = '0; m_act = '0;
      m_lev = '0; m_nar = '0; m_pc = 0; m_ts = 0; m_ovf = 0;
      foreach (m_fc[i]) m_fc[i] = 0;
      q_ts.delete(); q_mask.delete(); q_lev.delete();
    end else begin
      bit tk, setovf;
      bit [NCH-1:0] nl, mk, seen;
      int pre;
      tk = (m_pc >= int'(presc_div));
      seen = m_act | (m_s2 ^ m_s2d);
      nl = m_lev;
      for (int i = 0; i < NCH; i++) begin
        if (tk) begin
          if (!filt_en) begin
            nl[i] = m_s2[i]; m_fc[i] = 0;
          end else if (m_s2[i] != m_lev[i]) begin
            if (m_fc[i] >= int'(filt_len)) begin nl[i] = m_s2[i]; m_fc[i] = 0; end
            else m_fc[i] = m_fc[i] + 1;
          end else m_fc[i] = 0;
        end
      end
      if (narrow_clr) m_nar = '0;
      if (tk) m_nar = m_nar | (ch_enable & seen & ~(m_s2 ^ m_raw));
      mk = (nl ^ m_lev) & ch_enable;
      pre = q_ts.size();
      setovf = 0;
      if (tk && mk != '0) begin
        if (pre < DEPTH) begin
          q_ts.push_back(m_ts); q_mask.push_back(mk); q_lev.push_back(nl);
        end else setovf = 1;
      end
      if (rd_en && pre > 0) begin
        void'(q_ts.pop_front()); void'(q_mask.pop_front()); void'(q_lev.pop_front());
      end
      m_ovf = setovf | (m_ovf & !ovf_clr);
      if (tk) begin
        m_lev = nl; m_raw = m_s2; m_act = '0; m_ts = m_ts + 1; m_pc = 0;
      end else begin
        m_act = seen; m_pc = m_pc + 1;
      end
      m_s2d = m_s2; m_s2 = m_s1; m_s1 = din;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_valid == (q_ts.size() > 0), "R10 rd_valid", rd_valid, q_ts.size() > 0);
      if (rd_valid && q_ts.size() > 0) begin
        chk(rd_ts == q_ts[0], "R3 timestamp", rd_ts, q_ts[0]);
        chk(rd_mask == q_mask[0], "R3 mask", rd_mask, q_mask[0]);
        chk(rd_levels == q_lev[0], "R3 levels", rd_levels, q_lev[0]);
      end
      chk(overflow == m_ovf, "R9 overflow", overflow, m_ovf);
      chk(narrow_flag == m_nar, "R6 narrow", narrow_flag, m_nar);
    end
  end

  task automatic reset_dut(input int div);
    @(negedge clk);
    rst_n = 1'b0; din = '0; presc_div = 16'(div); rd_en = 0;
    ovf_clr = 0; narrow_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pop(output logic v, output logic [31:0] t,
                     output logic [NCH-1:0] m, output logic [NCH-1:0] l);
    @(negedge clk);
    v = rd_valid; t = rd_ts; m = rd_mask; l = rd_levels;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic v; logic [31:0] t1, t2; logic [NCH-1:0] m, l;
    int n;
    reset_dut(3);
    @(negedge clk);
    // R11 reset state
    chk(!rd_valid && !overflow && narrow_flag == '0, "R11 reset", {rd_valid, overflow}, 0);

    // R1: two channels change together
    din[1] = 1; din[9] = 1;
    repeat (40) @(negedge clk);
    // R2: falling edge on channel 1, 40 clocks later
    din[1] = 0;
    repeat (12) @(negedge clk);
    pop(v, t1, m, l);
    chk(v && m == 32'h0202 && l == 32'h0202, "R1 joint record", m, 32'h0202);
    pop(v, t2, m, l);
    chk(v && m == 32'h0002 && l == 32'h0200, "R2 falling record", m, 32'h0002);
    chk(t2 - t1 == 10, "R4 tick spacing", t2 - t1, 10);
    @(negedge clk);
    // R10 read on empty
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(!rd_valid, "R10 empty read", rd_valid, 0);

    // R5: change just before a tick is not yet accepted
    reset_dut(0);
    din[4] = 1; @(negedge clk);
    chk(!rd_valid, "R5 sync delay", rd_valid, 0);
    @(negedge clk); @(negedge clk);
    chk(rd_valid, "R5 after sync", rd_valid, 1);

    // R6: narrow pulse between ticks
    reset_dut(7);
    @(negedge clk);
    while (m_pc != 0) @(negedge clk);
    din[3] = 1; repeat (2) @(negedge clk); din[3] = 0;
    repeat (12) @(negedge clk);
    chk(narrow_flag[3] && !rd_valid, "R6 narrow set", narrow_flag, 32'h8);
    narrow_clr = 1; @(negedge clk); narrow_clr = 0; @(negedge clk);
    chk(narrow_flag == '0, "R6 narrow clear", narrow_flag, 0);

    // R8: disabled channel toggles, wide and narrow
    ch_enable[5] = 0;
    din[5] = 1; repeat (20) @(negedge clk);
    while (m_pc != 0) @(negedge clk);
    din[5] = 0; @(negedge clk); din[5] = 1; @(negedge clk); din[5] = 0;
    repeat (20) @(negedge clk);
    chk(!rd_valid && narrow_flag == '0, "R8 disabled", {rd_valid, narrow_flag[5]}, 0);
    ch_enable = '1;

    // R7: glitch filter
    reset_dut(0);
    filt_en = 1; filt_len = 3;
    din[7] = 1; repeat (3) @(negedge clk); din[7] = 0;
    repeat (10) @(negedge clk);
    chk(!rd_valid, "R7 short pulse rejected", rd_valid, 0);
    din[7] = 1; repeat (8) @(negedge clk);
    chk(rd_valid && rd_mask == 32'h80, "R7 long pulse accepted", rd_mask, 32'h80);
    filt_en = 0;

    // R9: overflow
    reset_dut(1);
    for (int k = 0; k < 20; k++) begin
      din[0] = ~din[0]; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(overflow, "R9 overflow set", overflow, 1);
    n = 0;
    while (rd_valid) begin pop(v, t1, m, l); n++; end
    chk(n == DEPTH, "R9 depth", n, DEPTH);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk);
    chk(!overflow, "R9 overflow clear", overflow, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule